// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a synchronous static RAM whose data bus never idles. A read or a write may be issued at every enabled rising clock edge. The edge that registers an address also registers its control inputs. Read data returns on the second enabled edge after its address. Write data is taken on the second enabled edge after its address. Because both directions share one latency, reads and writes can alternate in any pattern with no dead cycles between them.

A load cycle starts an access at an external address. An advance cycle steps a two-bit burst counter and repeats the operation of the last load. The default step is linear, and a parameter selects an XOR step instead. A low chip-enable on a load cycle makes the access real. A high chip-enable makes it a deselect. An active-low clock enable freezes every register, including the array.

Internally, an accepted write sits in a one-entry buffer for one more enabled edge before it reaches the array. A read of the same word during that edge takes the buffered bytes instead of the stale array contents.

Top module: `nowait_sram`

## Requirements
- R1: A read issued at enabled edge k drives its word on `rdata`, with `rvalid` high, right after enabled edge k+2.
- R2: A write issued at enabled edge k stores the `wdata` present at enabled edge k+2. Reads and writes may be issued back to back in any order with no idle cycles.
- R3: While `cke_n` is high, every input is ignored and `rdata`, `rvalid`, the pipeline and the array hold their values. Stalled cycles are not counted in the latency of R1 and R2.
- R4: On a load cycle (`adv` low, `ce_n` low), `we_n` low selects a write and `we_n` high selects a read.
- R5: Bit i of `be_n`, when low, enables byte lane i (bits 8i+7..8i) of the write issued in that cycle. Disabled lanes keep their old contents, and reads ignore `be_n`.
- R6: On an advance cycle (`adv` high), the burst count increments modulo 4. The address becomes the load address with bits 1..0 replaced by (load bits 1..0 + count) mod 4, and the upper bits are unchanged. The operation is the one from the last load, and `ce_n` and `we_n` are ignored.
- R7: A load cycle with `ce_n` high is a deselect. It makes no array access and gives `rvalid` low two enabled edges later. Advance cycles that follow a deselect are also deselects.
- R8: A read always returns the most recently written bytes. This holds when the write was issued only one or two cycles earlier.
- R9: When no read completes at an enabled edge, `rvalid` goes low and `rdata` keeps its previous value.
- R10: Reset (synchronous, `rst_n` low) clears `rdata` to 0, drops `rvalid`, empties the pipeline and makes the burst state a deselect. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| ce_n | input | 1 | Active-low chip enable, sampled on load cycles |
| we_n | input | 1 | Direction on load cycles: low write, high read |
| adv | input | 1 | High advances the burst, low loads `addr` |
| be_n | input | LANES (2) | Active-low per-lane write enables |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data, taken two enabled edges after its address |
| rdata | output | LANES*LANE_W (16) | Registered read data |
| rvalid | output | 1 | High when `rdata` carries a freshly completed read |

## Verification
The assertions assume that the inputs are known at every edge after reset and that reset is held for at least one edge before the first access. They also assume that every word is written before it is first read, because array contents are undefined at power-up. The stimulus keeps to these rules. It holds reset for three edges, then fills the whole array with full-word writes before any read. After that it drives random mixes of loads, bursts, deselects and stalls, which leave every input known in every cycle.

// File: rtl/nws_pkg.sv
package nws_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/nws_burst_addr.sv
module nws_burst_addr #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2,
    parameter bit LINEAR = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  step,
    output logic [ADDR_W-1:0] addr_o
);
    logic [CNT_W-1:0] low;

    generate
        if (LINEAR) begin : g_linear
            assign low = CNT_W'(base[CNT_W-1:0] + step);
        end else begin : g_xor
            assign low = base[CNT_W-1:0] ^ step;
        end
    endgenerate

    assign addr_o = {base[ADDR_W-1:CNT_W], low};
endmodule

// File: rtl/nws_lane_merge.sv
module nws_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] old_w,
    input  logic [LANES*LANE_W-1:0] new_w,
    input  logic [LANES-1:0]        sel,
    output logic [LANES*LANE_W-1:0] out_w
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign out_w[i*LANE_W +: LANE_W] = sel[i] ? new_w[i*LANE_W +: LANE_W]
                                                      : old_w[i*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/nws_array.sv
module nws_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wbe,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wbe[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
    import nws_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int LANES        = 2,
    parameter int LANE_W       = 8,
    parameter bit BURST_LINEAR = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    adv,
    input  logic [LANES-1:0]        be_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef struct packed {
        op_e              op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        stage_t            s2;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        op_e               bop;
        logic              wb_vld;
        logic [ADDR_W-1:0] wb_addr;
        logic [LANES-1:0]  wb_be;
        logic [DATA_W-1:0] wb_data;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]  cnt_inc;
    logic [ADDR_W-1:0] burst_addr;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] fwd_data;
    logic [LANES-1:0]  fwd_sel;
    logic              mem_we;
    logic              s1_rd, s1_wr, s2_rd;
    op_e               load_op;

    assign cnt_inc = CNT_W'(st_q.cnt + 1'b1);
    assign load_op = ce_n ? OP_NONE : (we_n ? OP_RD : OP_WR);

    nws_burst_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LINEAR (BURST_LINEAR)
    ) u_baddr (
        .base   (st_q.base),
        .step   (cnt_inc),
        .addr_o (burst_addr)
    );

    // buffered write reaches the array at the next enabled edge
    assign mem_we = st_q.wb_vld && !cke_n;

    nws_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.wb_addr),
        .wbe   (st_q.wb_be),
        .wdata (st_q.wb_data),
        .raddr (st_q.s2.addr),
        .rdata (arr_rd)
    );

    // a read meeting the buffered write takes its enabled lanes
    assign fwd_sel = (st_q.wb_vld && (st_q.wb_addr == st_q.s2.addr)) ? st_q.wb_be : '0;

    nws_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_fwd (
        .old_w (arr_rd),
        .new_w (st_q.wb_data),
        .sel   (fwd_sel),
        .out_w (fwd_data)
    );

    always_comb begin
        st_d = st_q;
        if (!cke_n) begin
            // issue stage
            if (adv) begin
                st_d.cnt     = cnt_inc;
                st_d.s1.op   = st_q.bop;
                st_d.s1.addr = burst_addr;
            end else begin
                st_d.base    = addr;
                st_d.cnt     = '0;
                st_d.bop     = load_op;
                st_d.s1.op   = load_op;
                st_d.s1.addr = addr;
            end
            st_d.s1.be = ~be_n;
            // second stage
            st_d.s2 = st_q.s1;
            // data stage
            st_d.wb_vld  = (st_q.s2.op == OP_WR);
            st_d.wb_addr = st_q.s2.addr;
            st_d.wb_be   = st_q.s2.be;
            st_d.wb_data = wdata;
            if (st_q.s2.op == OP_RD) begin
                st_d.rdata  = fwd_data;
                st_d.rvalid = 1'b1;
            end else begin
                st_d.rvalid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
    assign s1_rd  = (st_q.s1.op == OP_RD);
    assign s1_wr  = (st_q.s1.op == OP_WR);
    assign s2_rd  = (st_q.s2.op == OP_RD);
endmodule

// File: rtl/nowait_sram_chk.sv
module nowait_sram_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          adv,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          s1_rd,
    input logic          s1_wr,
    input logic          s2_rd,
    input logic          mem_we
);
    // R3: a stalled edge leaves the outputs untouched
    a_r3_freeze_out: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rdata) && $stable(rvalid)));

    // R3: the array is never written during a stall
    a_r3_no_array_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cke_n);

    // R1: a read in the second stage completes at the next enabled edge
    a_r1_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_rd) |=> rvalid);

    // R9: no read in the second stage means no valid flag
    a_r9_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !s2_rd) |=> !rvalid);

    // R7: a deselecting load enters the pipe as no operation
    a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && ce_n) |=> (!s1_rd && !s1_wr));

    // R4: a selected load with we_n low enters as a write
    a_r4_load_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !ce_n && !we_n) |=> s1_wr);
endmodule

bind nowait_sram nowait_sram_chk #(.DW(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_n  (cke_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .adv    (adv),
    .rdata  (rdata),
    .rvalid (rvalid),
    .s1_rd  (s1_rd),
    .s1_wr  (s1_wr),
    .s2_rd  (s2_rd),
    .mem_we (mem_we)
);

// File: tb/sim_nowait_sram.sv
`timescale 1ns/1ps
module sim_nowait_sram;
    localparam int AW = 8;
    localparam int NL = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          adv = 1'b0;
    logic [NL-1:0] be_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #10 clk = ~clk;

    nowait_sram u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_n(ce_n), .we_n(we_n),
        .adv(adv), .be_n(be_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    // behavioural reference: 0 none, 1 read, 2 write
    logic [DW-1:0] mem [1<<AW];
    int            pk [2];
    logic [AW-1:0] pa [2];
    logic [NL-1:0] pb [2];
    int            bk;
    logic [AW-1:0] bbase;
    logic [1:0]    bcnt;
    logic [DW-1:0] er;
    logic          ev;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic model_reset();
        pk[0] = 0; pk[1] = 0; pa[0] = '0; pa[1] = '0; pb[0] = '0; pb[1] = '0;
        bk = 0; bbase = '0; bcnt = '0; er = '0; ev = 1'b0;
    endtask

    task automatic cyc(string tag, bit ck, bit ce, bit we, bit ad,
                       logic [NL-1:0] be, logic [AW-1:0] a);
        int            nk;
        logic [AW-1:0] na;
        @(negedge clk);
        cke_n = ck; ce_n = ce; we_n = we; adv = ad; be_n = be; addr = a;
        wdata = DW'($urandom);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            model_reset();
        end else if (!ck) begin
            if (pk[1] == 2) begin
                for (int i = 0; i < NL; i++)
                    if (pb[1][i]) mem[pa[1]][i*8 +: 8] = wdata[i*8 +: 8];
                ev = 1'b0;
            end else if (pk[1] == 1) begin
                er = mem[pa[1]];
                ev = 1'b1;
            end else begin
                ev = 1'b0;
            end
            pk[1] = pk[0]; pa[1] = pa[0]; pb[1] = pb[0];
            if (ad) begin
                bcnt = bcnt + 2'd1;
                na = {bbase[AW-1:2], 2'(bbase[1:0] + bcnt)};
                nk = bk;
            end else begin
                bbase = a; bcnt = '0;
                bk = ce ? 0 : (we ? 1 : 2);
                nk = bk; na = a;
            end
            pk[0] = nk; pa[0] = na; pb[0] = ~be;
        end
        n_chk++;
        if (rvalid !== ev) begin
            n_bad++;
            $display("FAIL %s rvalid actual %b expected %b at %0t", tag, rvalid, ev, $time);
        end
        n_chk++;
        if (rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata actual %h expected %h at %0t", tag, rdata, er, $time);
        end
    endtask

    task automatic rnd_phase(string tag, int n, int p_stall, int p_adv, int p_desel,
                             int amask);
        for (int j = 0; j < n; j++) begin
            cyc(tag, ($urandom % 100) < p_stall, ($urandom % 100) < p_desel,
                $urandom % 2, ($urandom % 100) < p_adv, NL'($urandom),
                AW'($urandom) & AW'(amask));
        end
    endtask

    initial begin
        model_reset();
        // R10: reset state
        for (int j = 0; j < 3; j++) cyc("R10", 0, 1, 1, 0, '1, '0);
        rst_n = 1'b1;
        // R4 R5: full-word fill of every address
        for (int j = 0; j < (1 << AW); j++) cyc("R4 R5", 0, 0, 0, 0, '0, AW'(j));
        cyc("R7", 0, 1, 1, 0, '1, '0);
        cyc("R7", 0, 1, 1, 0, '1, '0);
        // R8: write then immediate reads, partial lanes
        cyc("R8", 0, 0, 0, 0, 2'b10, 8'h21);
        cyc("R8", 0, 0, 1, 0, 2'b00, 8'h21);
        cyc("R8", 0, 0, 1, 0, 2'b00, 8'h21);
        cyc("R8", 0, 0, 0, 0, 2'b01, 8'h21);
        cyc("R8", 0, 0, 1, 0, 2'b11, 8'h21);
        cyc("R8", 0, 1, 1, 0, '1, '0);
        cyc("R8", 0, 1, 1, 0, '1, '0);
        cyc("R8", 0, 1, 1, 0, '1, '0);
        // R6: read burst wrapping inside a group of four
        cyc("R6", 0, 0, 1, 0, '1, 8'h4E);
        cyc("R6", 0, 0, 0, 1, '1, 8'h00);
        cyc("R6", 0, 0, 0, 1, '1, 8'h00);
        cyc("R6", 0, 0, 0, 1, '1, 8'h00);
        cyc("R6", 0, 0, 0, 1, '1, 8'h00);
        // R7: deselect followed by bursts
        cyc("R7", 0, 1, 1, 0, '1, 8'h10);
        cyc("R7", 0, 0, 1, 1, '1, 8'h10);
        cyc("R7", 0, 0, 0, 1, '0, 8'h10);
        cyc("R7", 0, 1, 1, 0, '1, '0);
        cyc("R7", 0, 1, 1, 0, '1, '0);
        // R1 R2 R9: free mix, no stalls
        rnd_phase("R1 R2 R9", 1500, 0, 25, 10, 8'h0F);
        // R6: long bursts
        rnd_phase("R6", 800, 0, 75, 5, 8'hFF);
        // R3: stalls everywhere
        rnd_phase("R3", 1500, 35, 30, 10, 8'h07);
        // R7: heavy deselect
        rnd_phase("R7", 500, 10, 40, 50, 8'h0F);
        // R5 R8: dense conflicts on few words
        rnd_phase("R5 R8", 1500, 5, 10, 0, 8'h03);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule